// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block is a register-mapped timer peripheral on a simple 32-bit single-cycle register bus. It holds a free-running 32-bit up-counting timestamp and two independent down-counting interval timers. Software starts a timer by writing one word to its reload register. The two low bits of that word are the control flags, and the upper bits give the period, so a period is always a multiple of four clocks.

Each timer runs either periodically or once. When a timer expires, or when the timestamp wraps, a bit is latched in a shared status register. Software clears that bit by writing 1 to it. Each status bit drives its own level interrupt line. Reads are combinational from the address, and every register is readable, so software can poll live counts at any time.

Top module: `dual_interval_timer`

## Requirements
- R1: While reset is active, and on the first clocks after it, every register reads zero and all interrupt lines are low.
- R2: In a reload word, bit 0 is the enable flag and bit 1 selects one-shot (1) or periodic (0). The period is bits 31:2, with its two low bits taken as zero. A reload register reads back the last word written to it. The current count of timer 0 reads at offset 0x04 and that of timer 1 at 0x0C.
- R3: A reload write with bit 0 set loads the period into the current count on the writing edge. The count then falls by one per clock. The timer expires on the P-th clock after the write, which sets its pending bit. A reload write on an expiry clock takes precedence, and that expiry does not happen.
- R4: In periodic mode, each expiry reloads the period into the count, and the timer expires again every P clocks.
- R5: In one-shot mode, an expiry clears bit 0 of the stored reload word and leaves the count at zero, and the timer stops.
- R6: While the enable bit is clear, the count and the reload word hold, and no expiry occurs. Writing all zeros to a reload register does this.
- R7: The timestamp at offset 0x00 counts up by one per clock. A write loads the written value, so writing zero resets it. A wrap from 0xFFFFFFFF to 0 sets status bit 2.
- R8: The status register is at offset 0x20. Bit 0 is timer 0 pending and bit 1 is timer 1 pending. Writing 1 to a bit clears it, and writing 0 leaves it as it is. If an expiry falls in the same clock as a clear of its bit, the bit stays set.
- R9: irq_o[i] is high exactly while status bit i is set. The pending bits stay set until software clears them.
- R10: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x20 read as zero. Writes to those offsets, and writes to the current-count offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 3 | Level interrupts: [0] timer 0, [1] timer 1, [2] timestamp wrap |

## Verification
Two events can land in the same clock. In the first, a software write-1 clear of a status bit arrives on the exact clock that its timer expires. The bench runs a four-clock periodic timer and times the clear write so that it lands on an expiry edge. It then requires the pending line to stay high. In the second, a reload write arrives on an expiry edge. The bench requires the write to win, with no new pending bit. A behavioural model that updates on every edge judges both cases, and directed cycle-counted checks do too.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int DW  = 32;
  localparam int AW  = 6;
  localparam int NCH = 2;
  localparam int NSRC = NCH + 1;

  localparam logic [AW-1:0] OFS_STAMP  = AW'(8'h00);
  localparam logic [AW-1:0] OFS_STATUS = AW'(8'h20);

  function automatic logic [AW-1:0] ofs_count(input int ch);
    return AW'(4 + 8 * ch);
  endfunction

  function automatic logic [AW-1:0] ofs_reload(input int ch);
    return AW'(8 + 8 * ch);
  endfunction
endpackage

// File: rtl/dit_rst_sync.sv
module dit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dit_stamp.sv
module dit_stamp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_we,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] stamp_o,
  output logic          wrap_o
);
  logic [DW-1:0] stamp_q, stamp_d;
  logic          stamp_ce;

  always_comb begin
    stamp_ce = 1'b1;
    wrap_o   = 1'b0;
    if (load_we) begin
      stamp_d = load_data;
    end else begin
      stamp_d = stamp_q + DW'(1);
      wrap_o  = (stamp_q == {DW{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stamp_q <= '0;
    else if (stamp_ce) stamp_q <= stamp_d;
  end

  assign stamp_o = stamp_q;
endmodule

// File: rtl/dit_chan.sv
module dit_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_we,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] reload_o,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  localparam int FLAG_W = 2;

  logic [DW-1:0] rld_q, rld_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] period;
  logic          run, once, ce;

  assign run    = rld_q[0];
  assign once   = rld_q[1];
  assign period = {rld_q[DW-1:FLAG_W], {FLAG_W{1'b0}}};

  always_comb begin
    rld_d    = rld_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    ce       = load_we | run;
    if (load_we) begin
      rld_d = load_data;
      if (load_data[0]) cnt_d = {load_data[DW-1:FLAG_W], {FLAG_W{1'b0}}};
    end else if (run) begin
      if ((cnt_q == '0) || (cnt_q == DW'(1))) begin
        expire_o = 1'b1;
        if (once) begin
          cnt_d    = '0;
          rld_d[0] = 1'b0;
        end else begin
          cnt_d = period;
        end
      end else begin
        cnt_d = cnt_q - DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      cnt_q <= '0;
    end else if (ce) begin
      rld_q <= rld_d;
      cnt_q <= cnt_d;
    end
  end

  assign reload_o = rld_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/dit_status.sv
module dit_status #(
  parameter int NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic          clr_we,
  input  logic [NS-1:0] clr_data,
  output logic [NS-1:0] pend_o
);
  logic [NS-1:0] pend_q, pend_d;
  logic          ce;

  always_comb begin
    ce     = clr_we | (|set_i);
    pend_d = (pend_q & ~({NS{clr_we}} & clr_data)) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pend_q <= '0;
    else if (ce) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int ADDR_W = dit_pkg::AW,
  parameter int DATA_W = dit_pkg::DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   irq_o
);
  logic                          rst_sn;
  logic                          wr_en;
  logic                          ts_wr, st_wr;
  logic [DATA_W-1:0]             ts_q;
  logic                          ts_wrap;
  logic [NCH-1:0]                rld_wr;
  logic [NCH-1:0][DATA_W-1:0]    rld_q;
  logic [NCH-1:0][DATA_W-1:0]    cnt_q;
  logic [NCH-1:0]                chan_exp;
  logic [NSRC-1:0]               pend_q;

  dit_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign wr_en = bus_sel & bus_wr;
  assign ts_wr = wr_en & (bus_addr == OFS_STAMP);
  assign st_wr = wr_en & (bus_addr == OFS_STATUS);

  dit_stamp #(.DW(DATA_W)) u_stamp (
    .clk(clk), .rst_n(rst_sn), .load_we(ts_wr), .load_data(bus_wdata),
    .stamp_o(ts_q), .wrap_o(ts_wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign rld_wr[g] = wr_en & (bus_addr == ofs_reload(g));
    dit_chan #(.DW(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_sn), .load_we(rld_wr[g]), .load_data(bus_wdata),
      .reload_o(rld_q[g]), .count_o(cnt_q[g]), .expire_o(chan_exp[g])
    );
  end

  dit_status #(.NS(NSRC)) u_status (
    .clk(clk), .rst_n(rst_sn), .set_i({ts_wrap, chan_exp}),
    .clr_we(st_wr), .clr_data(bus_wdata[NSRC-1:0]), .pend_o(pend_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_STAMP)  bus_rdata = ts_q;
    if (bus_addr == OFS_STATUS) bus_rdata = {{(DATA_W-NSRC){1'b0}}, pend_q};
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ofs_count(i))  bus_rdata = cnt_q[i];
      if (bus_addr == ofs_reload(i)) bus_rdata = rld_q[i];
    end
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [DW-1:0] ts_q,
  input logic          ts_wr,
  input logic [DW-1:0] cnt0,
  input logic [DW-1:0] rld0,
  input logic          rld_wr0,
  input logic          exp0,
  input logic          st_wr,
  input logic          wdata0,
  input logic          pend0,
  input logic          irq0
);
  assert_ts_inc_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !ts_wr |=> ts_q == $past(ts_q) + 32'd1);

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    exp0 && rld0[1] && !rld_wr0 |=> !rld0[0] && cnt0 == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    exp0 |=> pend0);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    st_wr && wdata0 && !exp0 |=> !pend0);

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !rld0[0] && !rld_wr0 |=> $stable(cnt0) && $stable(rld0));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq0) |-> $past(exp0));
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .ts_q(ts_q), .ts_wr(ts_wr),
  .cnt0(cnt_q[0]), .rld0(rld_q[0]), .rld_wr0(rld_wr[0]), .exp0(chan_exp[0]),
  .st_wr(st_wr), .wdata0(bus_wdata[0]), .pend0(pend_q[0]), .irq0(irq_o[0])
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] m_ts;
  logic [31:0] m_rld [2];
  logic [31:0] m_cnt [2];
  logic [2:0]  m_pend;
  int          settle;

  always @(posedge clk or negedge rst_n) begin
    logic [2:0] fired;
    if (!rst_n) begin
      m_ts = 0; m_pend = 0; settle = 0;
      for (int c = 0; c < 2; c++) begin m_rld[c] = 0; m_cnt[c] = 0; end
    end else if (settle < 2) begin
      settle++;
    end else begin
      fired = 0;
      for (int c = 0; c < 2; c++) begin
        if (bus_sel && bus_wr && bus_addr == 6'(8 + 8*c)) begin
          m_rld[c] = bus_wdata;
          if (bus_wdata[0]) m_cnt[c] = bus_wdata & 32'hFFFF_FFFC;
        end else if (m_rld[c][0]) begin
          if (m_cnt[c] < 2) begin
            fired[c] = 1;
            if (m_rld[c][1]) begin m_cnt[c] = 0; m_rld[c][0] = 0; end
            else m_cnt[c] = m_rld[c] & 32'hFFFF_FFFC;
          end else m_cnt[c] = m_cnt[c] - 1;
        end
      end
      if (bus_sel && bus_wr && bus_addr == 6'h00) m_ts = bus_wdata;
      else begin
        if (m_ts == 32'hFFFF_FFFF) fired[2] = 1;
        m_ts = m_ts + 1;
      end
      if (bus_sel && bus_wr && bus_addr == 6'h20) m_pend = m_pend & ~bus_wdata[2:0];
      m_pend = m_pend | fired;
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_ts;
      6'h04: return m_cnt[0];
      6'h08: return m_rld[0];
      6'h0C: return m_cnt[1];
      6'h10: return m_rld[1];
      6'h20: return {29'd0, m_pend};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00: return "R7";
      6'h04, 6'h0C: return "R3";
      6'h08, 6'h10: return "R2";
      6'h20: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && settle >= 2 && !done) begin
      chk("R9", {29'd0, irq_o}, {29'd0, m_pend});
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(3);
    // R1 reset state
    peek(6'h08, 0, "R1"); peek(6'h10, 0, "R1"); peek(6'h20, 0, "R1");
    chk("R1", {29'd0, irq_o}, 0);

    // R2/R3: period 12 (low bits of 0xD are flags), enable, periodic
    wr(6'h08, 32'h0000_000D);
    peek(6'h04, 12, "R2");
    peek(6'h08, 32'hD, "R2");
    step(11); chk("R3", {31'd0, irq_o[0]}, 0);
    step(1);  chk("R3", {31'd0, irq_o[0]}, 1);
    peek(6'h04, 12, "R4");
    // clear (edge k+14), next expiry at k+24
    wr(6'h20, 32'h1); chk("R8", {31'd0, irq_o[0]}, 0);
    step(9); chk("R4", {31'd0, irq_o[0]}, 0);
    step(1); chk("R4", {31'd0, irq_o[0]}, 1);

    // R6: disable, count freezes at 11
    wr(6'h08, 0);
    peek(6'h04, 11, "R6");
    wr(6'h20, 32'h1);
    step(30);
    chk("R6", {31'd0, irq_o[0]}, 0);
    peek(6'h04, 11, "R6");

    // R5: one-shot, period 16, on timer 1
    wr(6'h10, 32'h13);
    step(15); chk("R5", {31'd0, irq_o[1]}, 0);
    step(1);  chk("R5", {31'd0, irq_o[1]}, 1);
    peek(6'h0C, 0, "R5"); peek(6'h10, 32'h12, "R5");
    step(20);
    peek(6'h0C, 0, "R5"); chk("R9", {31'd0, irq_o[1]}, 1);

    // R8: writing 0 keeps, writing 1 clears
    wr(6'h20, 0); chk("R8", {31'd0, irq_o[1]}, 1);
    wr(6'h20, 32'h2); chk("R8", {31'd0, irq_o[1]}, 0);

    // R8 overlap: period 4 periodic, clear lands on expiry edge m+8
    wr(6'h10, 32'h5);
    step(6);
    wr(6'h20, 32'h2); chk("R8", {31'd0, irq_o[1]}, 1);
    wr(6'h20, 32'h2); chk("R8", {31'd0, irq_o[1]}, 0);
    // R3: disabling write on expiry edge m+12 wins
    wr(6'h10, 0); chk("R3", {31'd0, irq_o[1]}, 0);
    step(8); chk("R6", {31'd0, irq_o[1]}, 0);

    // R7: timestamp load and wrap
    wr(6'h00, 32'hFFFF_FFFC);
    peek(6'h00, 32'hFFFF_FFFC, "R7");
    step(3); chk("R7", {31'd0, irq_o[2]}, 0);
    step(1); chk("R7", {31'd0, irq_o[2]}, 1);
    peek(6'h00, 0, "R7");
    wr(6'h00, 0); peek(6'h00, 0, "R7");
    wr(6'h20, 32'h4); chk("R8", {31'd0, irq_o[2]}, 0);

    // R10: unmapped reads, ignored writes
    peek(6'h14, 0, "R10"); peek(6'h24, 0, "R10"); peek(6'h02, 0, "R10");
    wr(6'h04, 32'h55); peek(6'h04, 11, "R10");
    wr(6'h18, 32'hFFFF_FFFF); peek(6'h18, 0, "R10");
    chk("R10", {29'd0, irq_o}, 0);

    step(5);
    summary();
  end
endmodule